// File: doc/BRIEF.md
# DSI Video Line Packetizer

This block decides, for every active video line, which DSI video-mode packets go out on the link and how large each one is. A line-start pulse starts a line. The block captures the line configuration on that pulse: the mode type, the packet size in pixels, the chunk count, the null-packet size in bytes, the bytes per pixel, the lane count and the active pixel count. It then issues a series of packet descriptors over a valid/ready handshake. Each descriptor carries a kind (pixel stream or null filler) and a payload length in bytes.

In burst mode the whole active line leaves as one pixel packet. In non-burst mode the line is cut into chunks. Each chunk is one pixel packet of the programmed size, optionally followed by a null packet that pads the link time.

For every pixel packet accepted downstream, the block reports how many lane-byte-clock cycles the chunk occupies. This lets a neighbouring rate matcher compare link time against the pixel-clock time of the line. The block also flags a chunk layout that does not add up to the active width, and it counts line starts that arrive while a line is still being scheduled. Header, checksum and PHY generation happen elsewhere.

Top module: `vid_line_pktzr`

## Requirements
- R1: After reset, `dsc_valid` is 0, `cyc_valid` is 0, `layout_err` is 0 and `drop_cnt` is 0.
- R2: A mode value with bit 1 set (2'b10 or 2'b11) selects burst mode. The line is then one pixel descriptor of `act_px * px_bytes` bytes, and the chunk count and null size have no effect.
- R3: Mode values 2'b00 and 2'b01 both select non-burst mode and produce the same schedule. With a chunk count N > 0, the line is N pixel descriptors of `pkt_px * px_bytes` bytes each.
- R4: In non-burst mode with a chunk count of 0, the line is a single pixel descriptor of `act_px * px_bytes` bytes, and no null descriptor follows.
- R5: In non-burst mode with N > 0 and a null size S > 0, a null descriptor (`dsc_kind` = 1) of S bytes follows every pixel descriptor (`dsc_kind` = 0), including when N = 1. A null size of 0 produces no null descriptors.
- R6: The first descriptor is valid in the cycle after an accepted line start. A descriptor stays valid and unchanged until the cycle in which `dsc_ready` is high, and the next descriptor appears in the following cycle.
- R7: One cycle after each accepted pixel descriptor, `cyc_valid` pulses for one cycle. At the same time `cyc_count` equals ceil(C / L). C is the pixel bytes + 12 + S when null packets are active, and the pixel bytes + 6 otherwise. L is `lanes`, with a code of 0 treated as 1.
- R8: `layout_err` is updated at each accepted line start and holds until the next one. It is 1 exactly when the mode is non-burst, N > 0 and `pkt_px * N` differs from `act_px`.
- R9: A line start that arrives while a line is scheduled is dropped, and it increments `drop_cnt`, which saturates at its maximum. The exception is a line start in the cycle that accepts the final descriptor: that one starts the next line, and the count is unchanged.
- R10: The configuration is sampled only at an accepted line start. Changes to it during a line do not alter that line's descriptors or cycle counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_go | input | 1 | Line-start pulse |
| mode | input | 2 | Video mode type; bit 1 selects burst |
| pkt_px | input | PX_W | Pixels per non-burst packet |
| chunks | input | CH_W | Packets per line (0 means a single packet) |
| null_sz | input | NB_W | Null packet bytes (0 disables) |
| px_bytes | input | BPP_W | Bytes per pixel |
| lanes | input | LN_W | Data lane count (0 treated as 1) |
| act_px | input | PX_W | Active pixels per line |
| dsc_valid | output | 1 | Descriptor valid |
| dsc_ready | input | 1 | Descriptor accepted when high with valid |
| dsc_kind | output | 1 | 0 = pixel stream, 1 = null |
| dsc_bytes | output | PX_W+BPP_W | Payload length in bytes |
| cyc_valid | output | 1 | Chunk cycle count valid pulse |
| cyc_count | output | PX_W+BPP_W+2 | Lane-byte cycles of the chunk |
| layout_err | output | 1 | Chunk layout does not match the active width |
| drop_cnt | output | OV_W | Saturating count of dropped line starts |

## Verification
Two functions can land in the same cycle: a new line start and the handshake that retires the last descriptor of the current line. The testbench provokes this collision by timing a line-start pulse exactly N cycles after the previous start while ready is held high, with N the descriptor count. The reference model must then see the new schedule begin in the next cycle and the drop count stay unchanged. The opposite case is also exercised: a line start one cycle before that final handshake, and a line start held high across a long line. Both must count drops, and the second drives the counter into saturation.

// File: rtl/vlp_pkg.sv
package vlp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PIX  = 2'd1,
        ST_NUL  = 2'd2
    } sched_st_e;

    localparam logic KIND_PIX  = 1'b0;
    localparam logic KIND_NULL = 1'b1;

    localparam int OVH_NULL   = 12;
    localparam int OVH_NONULL = 6;
endpackage

// File: rtl/vlp_plan.sv
module vlp_plan #(
    parameter int PX_W   = 12,
    parameter int CH_W   = 8,
    parameter int NB_W   = 10,
    parameter int BPP_W  = 3,
    parameter int BY_W   = PX_W + BPP_W,
    parameter int COST_W = BY_W + 2
) (
    input  logic [1:0]        mode,
    input  logic [PX_W-1:0]   pkt_px,
    input  logic [CH_W-1:0]   chunks,
    input  logic [NB_W-1:0]   null_sz,
    input  logic [BPP_W-1:0]  px_bytes,
    input  logic [PX_W-1:0]   act_px,
    output logic              null_on,
    output logic [CH_W-1:0]   last_idx,
    output logic [BY_W-1:0]   pix_bytes,
    output logic [COST_W-1:0] cost,
    output logic              layout_bad
);
    import vlp_pkg::*;

    localparam int PR_W = PX_W + CH_W;

    logic            multi;
    logic [PX_W-1:0] line_px;
    logic [PR_W-1:0] span;

    always_comb begin
        multi     = !mode[1] && (chunks != '0);
        null_on   = multi && (null_sz != '0);
        last_idx  = multi ? chunks - CH_W'(1) : '0;
        line_px   = multi ? pkt_px : act_px;
        pix_bytes = BY_W'(line_px) * BY_W'(px_bytes);
        if (null_on)
            cost = COST_W'(pix_bytes) + COST_W'(OVH_NULL) + COST_W'(null_sz);
        else
            cost = COST_W'(pix_bytes) + COST_W'(OVH_NONULL);
        span       = PR_W'(pkt_px) * PR_W'(chunks);
        layout_bad = multi && (span != PR_W'(act_px));
    end
endmodule

// File: rtl/vlp_ceil_div.sv
module vlp_ceil_div #(
    parameter int COST_W = 17,
    parameter int LN_W   = 3
) (
    input  logic [COST_W-1:0] cost,
    input  logic [LN_W-1:0]   lanes,
    output logic [COST_W-1:0] quot
);
    logic [COST_W:0] den;
    logic [COST_W:0] num;

    always_comb begin
        den  = (lanes == '0) ? (COST_W+1)'(1) : (COST_W+1)'(lanes);
        num  = {1'b0, cost} + den - (COST_W+1)'(1);
        quot = COST_W'(num / den);
    end
endmodule

// File: rtl/vlp_sched.sv
module vlp_sched #(
    parameter int CH_W   = 8,
    parameter int NB_W   = 10,
    parameter int BY_W   = 15,
    parameter int COST_W = 17,
    parameter int LN_W   = 3,
    parameter int OV_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_go,
    input  logic              null_on,
    input  logic [CH_W-1:0]   last_idx,
    input  logic [BY_W-1:0]   pix_bytes,
    input  logic [NB_W-1:0]   null_sz,
    input  logic [COST_W-1:0] cost,
    input  logic [LN_W-1:0]   lanes,
    input  logic              layout_bad,
    input  logic              dsc_ready,
    output logic              dsc_valid,
    output logic              dsc_kind,
    output logic [BY_W-1:0]   dsc_bytes,
    output logic              pix_take,
    output logic [COST_W-1:0] cost_q,
    output logic [LN_W-1:0]   lanes_q,
    output logic              layout_err,
    output logic [OV_W-1:0]   drop_cnt
);
    import vlp_pkg::*;

    typedef struct packed {
        sched_st_e         st;
        logic [CH_W-1:0]   idx;
        logic              null_on;
        logic [CH_W-1:0]   last_idx;
        logic [BY_W-1:0]   pix_bytes;
        logic [NB_W-1:0]   null_sz;
        logic [COST_W-1:0] cost;
        logic [LN_W-1:0]   lanes;
        logic              err;
        logic [OV_W-1:0]   drops;
    } sched_t;

    sched_t s_d, s_q;
    logic   take;
    logic   at_last;
    logic   fin_take;
    logic   start_ok;

    always_comb begin
        s_d      = s_q;
        take     = (s_q.st != ST_IDLE) && dsc_ready;
        at_last  = (s_q.idx == s_q.last_idx);
        fin_take = take && at_last && ((s_q.st == ST_NUL) || !s_q.null_on);
        start_ok = line_go && ((s_q.st == ST_IDLE) || fin_take);

        if (take) begin
            unique case (s_q.st)
                ST_PIX: begin
                    if (s_q.null_on) begin
                        s_d.st = ST_NUL;
                    end else if (at_last) begin
                        s_d.st = ST_IDLE;
                    end else begin
                        s_d.idx = s_q.idx + CH_W'(1);
                    end
                end
                ST_NUL: begin
                    if (at_last) begin
                        s_d.st = ST_IDLE;
                    end else begin
                        s_d.st  = ST_PIX;
                        s_d.idx = s_q.idx + CH_W'(1);
                    end
                end
                default: s_d.st = ST_IDLE;
            endcase
        end

        if (start_ok) begin
            s_d.st        = ST_PIX;
            s_d.idx       = '0;
            s_d.null_on   = null_on;
            s_d.last_idx  = last_idx;
            s_d.pix_bytes = pix_bytes;
            s_d.null_sz   = null_sz;
            s_d.cost      = cost;
            s_d.lanes     = lanes;
            s_d.err       = layout_bad;
        end else if (line_go && (s_q.drops != '1)) begin
            s_d.drops = s_q.drops + OV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign dsc_valid  = (s_q.st != ST_IDLE);
    assign dsc_kind   = (s_q.st == ST_NUL) ? KIND_NULL : KIND_PIX;
    assign dsc_bytes  = (s_q.st == ST_NUL) ? BY_W'(s_q.null_sz) : s_q.pix_bytes;
    assign pix_take   = take && (s_q.st == ST_PIX);
    assign cost_q     = s_q.cost;
    assign lanes_q    = s_q.lanes;
    assign layout_err = s_q.err;
    assign drop_cnt   = s_q.drops;

    // R6: a stalled descriptor is held unchanged
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dsc_valid && !dsc_ready |=> dsc_valid && $stable(dsc_kind) && $stable(dsc_bytes));

    // R5: null descriptors never carry zero bytes
    assert_null_size_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dsc_valid && (dsc_kind == KIND_NULL) |-> (dsc_bytes != '0));

    // R5: an accepted pixel packet with null padding is followed by a null packet
    assert_null_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pix_take && s_q.null_on |=> dsc_valid && (dsc_kind == KIND_NULL));

    // R9: a line start during a line that is not finishing bumps the drop count
    assert_drop_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
        line_go && dsc_valid && !fin_take |=>
            (drop_cnt == $past(drop_cnt) + OV_W'(1)) || ($past(drop_cnt) == '1));
endmodule

// File: rtl/vid_line_pktzr.sv
module vid_line_pktzr #(
    parameter int PX_W  = 12,
    parameter int CH_W  = 8,
    parameter int NB_W  = 10,
    parameter int BPP_W = 3,
    parameter int LN_W  = 3,
    parameter int OV_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    line_go,
    input  logic [1:0]              mode,
    input  logic [PX_W-1:0]         pkt_px,
    input  logic [CH_W-1:0]         chunks,
    input  logic [NB_W-1:0]         null_sz,
    input  logic [BPP_W-1:0]        px_bytes,
    input  logic [LN_W-1:0]         lanes,
    input  logic [PX_W-1:0]         act_px,
    output logic                    dsc_valid,
    input  logic                    dsc_ready,
    output logic                    dsc_kind,
    output logic [PX_W+BPP_W-1:0]   dsc_bytes,
    output logic                    cyc_valid,
    output logic [PX_W+BPP_W+1:0]   cyc_count,
    output logic                    layout_err,
    output logic [OV_W-1:0]         drop_cnt
);
    import vlp_pkg::*;

    localparam int BY_W   = PX_W + BPP_W;
    localparam int COST_W = BY_W + 2;

    logic              p_null_on;
    logic [CH_W-1:0]   p_last_idx;
    logic [BY_W-1:0]   p_pix_bytes;
    logic [COST_W-1:0] p_cost;
    logic              p_bad;
    logic              pix_take;
    logic [COST_W-1:0] cost_q;
    logic [LN_W-1:0]   lanes_q;
    logic [COST_W-1:0] quot;

    vlp_plan #(
        .PX_W(PX_W), .CH_W(CH_W), .NB_W(NB_W), .BPP_W(BPP_W),
        .BY_W(BY_W), .COST_W(COST_W)
    ) u_plan (
        .mode(mode), .pkt_px(pkt_px), .chunks(chunks), .null_sz(null_sz),
        .px_bytes(px_bytes), .act_px(act_px),
        .null_on(p_null_on), .last_idx(p_last_idx), .pix_bytes(p_pix_bytes),
        .cost(p_cost), .layout_bad(p_bad)
    );

    vlp_sched #(
        .CH_W(CH_W), .NB_W(NB_W), .BY_W(BY_W), .COST_W(COST_W),
        .LN_W(LN_W), .OV_W(OV_W)
    ) u_sched (
        .clk(clk), .rst_n(rst_n), .line_go(line_go),
        .null_on(p_null_on), .last_idx(p_last_idx), .pix_bytes(p_pix_bytes),
        .null_sz(null_sz), .cost(p_cost), .lanes(lanes), .layout_bad(p_bad),
        .dsc_ready(dsc_ready), .dsc_valid(dsc_valid), .dsc_kind(dsc_kind),
        .dsc_bytes(dsc_bytes), .pix_take(pix_take), .cost_q(cost_q),
        .lanes_q(lanes_q), .layout_err(layout_err), .drop_cnt(drop_cnt)
    );

    vlp_ceil_div #(.COST_W(COST_W), .LN_W(LN_W)) u_div (
        .cost(cost_q), .lanes(lanes_q), .quot(quot)
    );

    typedef struct packed {
        logic              cv;
        logic [COST_W-1:0] cyc;
    } tm_t;

    tm_t tm_d, tm_q;

    always_comb begin
        tm_d.cv  = pix_take;
        tm_d.cyc = pix_take ? quot : tm_q.cyc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tm_q <= '0;
        end else begin
            tm_q <= tm_d;
        end
    end

    assign cyc_valid = tm_q.cv;
    assign cyc_count = tm_q.cyc;

    logic [COST_W+LN_W:0] lane_eff;
    always_comb lane_eff = (lanes_q == '0) ? (COST_W+LN_W+1)'(1) : (COST_W+LN_W+1)'(lanes_q);

    // R7: divider result is the tight ceiling of the latched cost over the lanes
    assert_ceil_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dsc_valid |-> ((COST_W+LN_W+1)'(quot) * lane_eff >= (COST_W+LN_W+1)'(cost_q)) &&
                      ((COST_W+LN_W+1)'(quot) * lane_eff <  (COST_W+LN_W+1)'(cost_q) + lane_eff));

    // R7: a cycle count pulse only follows an accepted pixel descriptor
    assert_cyc_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_valid |-> $past(dsc_valid && dsc_ready && (dsc_kind == KIND_PIX)));

    // R8: the layout flag moves only after a line start
    assert_layout_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(layout_err) |-> $past(line_go));
endmodule

// File: tb/vid_line_pktzr_bench.sv
module vid_line_pktzr_bench;
    localparam int PX_W = 12, CH_W = 8, NB_W = 10, BPP_W = 3, LN_W = 3, OV_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_go = 1'b0;
    logic [1:0] mode = 2'b00;
    logic [PX_W-1:0] pkt_px = '0;
    logic [CH_W-1:0] chunks = '0;
    logic [NB_W-1:0] null_sz = '0;
    logic [BPP_W-1:0] px_bytes = 3'd1;
    logic [LN_W-1:0] lanes = 3'd1;
    logic [PX_W-1:0] act_px = '0;
    logic dsc_ready = 1'b1;
    logic dsc_valid, dsc_kind, cyc_valid, layout_err;
    logic [PX_W+BPP_W-1:0] dsc_bytes;
    logic [PX_W+BPP_W+1:0] cyc_count;
    logic [OV_W-1:0] drop_cnt;

    always #10 clk = ~clk;

    vid_line_pktzr u_vid_line_pktzr (
        .clk(clk), .rst_n(rst_n), .line_go(line_go), .mode(mode), .pkt_px(pkt_px),
        .chunks(chunks), .null_sz(null_sz), .px_bytes(px_bytes), .lanes(lanes),
        .act_px(act_px), .dsc_valid(dsc_valid), .dsc_ready(dsc_ready),
        .dsc_kind(dsc_kind), .dsc_bytes(dsc_bytes), .cyc_valid(cyc_valid),
        .cyc_count(cyc_count), .layout_err(layout_err), .drop_cnt(drop_cnt)
    );

    typedef struct {
        bit kind;
        int bytes;
        int cyc;
    } ent_t;

    ent_t exp_q[$];
    bit   m_cv = 0;
    int   m_cyc = 0;
    bit   m_err = 0;
    int   m_drop = 0;

    int compared = 0;
    int mismatched = 0;
    string tag = "R1";
    bit bp_en = 0;
    bit [7:0] lfsr = 8'hA5;
    int cycles = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string what, input int act, input int expv);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    task automatic push_line();
        int l = (lanes == 0) ? 1 : int'(lanes);
        bit multi = !mode[1] && (chunks != 0);
        bit nen = multi && (null_sz != 0);
        int n = multi ? int'(chunks) : 1;
        int pb = (multi ? int'(pkt_px) : int'(act_px)) * int'(px_bytes);
        int cost = pb + (nen ? 12 + int'(null_sz) : 6);
        int cy = (cost + l - 1) / l;
        for (int i = 0; i < n; i++) begin
            exp_q.push_back('{kind: 1'b0, bytes: pb, cyc: cy});
            if (nen) exp_q.push_back('{kind: 1'b1, bytes: int'(null_sz), cyc: 0});
        end
        m_err = multi && (int'(pkt_px) * int'(chunks) != int'(act_px));
    endtask

    // compare, then advance the model to the state after the coming edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            bit busy;
            bit hs;
            bit fin;
            check(dsc_valid == (exp_q.size() > 0), "dsc_valid", int'(dsc_valid), int'(exp_q.size() > 0));
            if (dsc_valid && exp_q.size() > 0) begin
                check(dsc_kind == exp_q[0].kind, "dsc_kind", int'(dsc_kind), int'(exp_q[0].kind));
                check(int'(dsc_bytes) == exp_q[0].bytes, "dsc_bytes", int'(dsc_bytes), exp_q[0].bytes);
            end
            check(cyc_valid == m_cv, "cyc_valid", int'(cyc_valid), int'(m_cv));
            if (m_cv) check(int'(cyc_count) == m_cyc, "cyc_count", int'(cyc_count), m_cyc);
            check(int'(drop_cnt) == m_drop, "drop_cnt", int'(drop_cnt), m_drop);
            check(layout_err == m_err, "layout_err", int'(layout_err), int'(m_err));

            busy = exp_q.size() > 0;
            hs = busy && dsc_ready;
            fin = hs && exp_q.size() == 1;
            m_cv = hs && !exp_q[0].kind;
            if (m_cv) m_cyc = exp_q[0].cyc;
            if (hs) void'(exp_q.pop_front());
            if (line_go && (!busy || fin)) push_line();
            else if (line_go && m_drop < 255) m_drop++;
        end
    end

    always @(posedge clk) begin
        #1;
        dsc_ready = bp_en ? lfsr[0] : 1'b1;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            finished = 1;
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic pulse_go();
        @(posedge clk); #1 line_go = 1'b1;
        @(posedge clk); #1 line_go = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while ((exp_q.size() > 0 || dsc_valid) && n < 5000);
        repeat (2) @(posedge clk);
    endtask

    task automatic set_cfg(input logic [1:0] md, input int pk, input int ch, input int nb,
                           input int bp, input int ln, input int ac);
        @(posedge clk); #1;
        mode = md; pkt_px = PX_W'(pk); chunks = CH_W'(ch); null_sz = NB_W'(nb);
        px_bytes = BPP_W'(bp); lanes = LN_W'(ln); act_px = PX_W'(ac);
    endtask

    task automatic line(input string t);
        tag = t;
        pulse_go();
        wait_idle();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        tag = "R1";
        repeat (3) @(posedge clk);

        // R2: burst, chunk and null settings ignored; 100*3=300 bytes, ceil(306/4)=77
        set_cfg(2'b10, 25, 5, 7, 3, 4, 100); line("R2");
        set_cfg(2'b11, 40, 9, 0, 3, 4, 100); line("R2");
        // R3: non-burst, 4 x 75 bytes, ceil(81/2)=41; both sync variants
        set_cfg(2'b00, 25, 4, 0, 3, 2, 100); line("R3");
        set_cfg(2'b01, 25, 4, 0, 3, 2, 100); line("R3");
        // R5: null padding after each pixel packet, ceil(97/3)=33
        set_cfg(2'b01, 25, 4, 10, 3, 3, 100); line("R5");
        set_cfg(2'b00, 64, 1, 5, 2, 4, 64); line("R5");
        // R4: chunk count zero gives one packet with no null
        set_cfg(2'b00, 25, 0, 9, 2, 1, 77); line("R4");
        // R7: lane code zero acts as one lane
        set_cfg(2'b00, 33, 3, 3, 4, 0, 99); line("R7");
        // R8: 30*3 != 100
        set_cfg(2'b00, 30, 3, 0, 1, 1, 100); line("R8");
        set_cfg(2'b00, 50, 2, 0, 1, 1, 100); line("R8");
        // R6: random back-pressure
        bp_en = 1;
        set_cfg(2'b01, 10, 6, 4, 3, 2, 60); line("R6");
        set_cfg(2'b10, 10, 6, 4, 2, 3, 200); line("R6");
        bp_en = 0;
        repeat (2) @(posedge clk);
        // R10: change config while a line runs
        set_cfg(2'b00, 20, 4, 6, 3, 2, 80);
        tag = "R10";
        pulse_go();
        #1 mode = 2'b10; chunks = 8'd2; null_sz = '0; lanes = 3'd1; act_px = 12'd5;
        wait_idle();
        // R9: start on the final acceptance (6 descriptors) is accepted
        set_cfg(2'b00, 20, 3, 4, 1, 1, 60);
        tag = "R9";
        pulse_go();
        repeat (5) @(posedge clk);
        #1 line_go = 1'b1;
        @(posedge clk); #1 line_go = 1'b0;
        wait_idle();
        // R9: start one cycle earlier is dropped
        pulse_go();
        repeat (4) @(posedge clk);
        #1 line_go = 1'b1;
        @(posedge clk); #1 line_go = 1'b0;
        wait_idle();
        // R9: long line with line_go held high saturates the drop count
        set_cfg(2'b00, 1, 255, 1, 1, 1, 255);
        @(posedge clk); #1 line_go = 1'b1;
        repeat (300) @(posedge clk);
        #1 line_go = 1'b0;
        wait_idle();

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule